// File: doc/BRIEF.md
# Pending Interrupt Service Scheduler

This block keeps two bit vectors across its interrupt input pins: a request vector that records which pins have asked for service, and an in-service vector that records which level-sensitive pins have been handed out and not yet retired. On every clock it takes at most one pending pin, always the highest-numbered one, and issues a one-cycle dispatch strobe carrying that pin's number. A separate flag tells the surrounding logic whether any pin is still waiting.

The per-pin mask, trigger type and vector all come from a redirection table held outside the block. The controller also has a global enable. An end-of-interrupt port takes a vector and a strobe. The block searches the table for the lowest pin whose vector matches, and releases that pin from service. Picking the destination CPU is left to a later stage.

Top module: `irq_service_sched`

## Requirements
- R1: After reset the request and in-service vectors are all zero, `disp_valid` is low and `irq_pending` is low.
- R2: Pin 0 never sets its request bit. The request vector is left unchanged by a masked pin, and by any pin input while `en` is low.
- R3: For an unmasked level-type pin (`pin_trig` bit = 1) with `en` high, the request bit takes the pin input every cycle. It is set when the input is 1 and cleared when the input is 0.
- R4: For an unmasked edge-type pin (`pin_trig` bit = 0) with `en` high, an input of 1 sets the request bit. An input of 0 never clears it.
- R5: A pin is pending when its request bit is 1 and its in-service bit is 0. Each cycle the highest-numbered pending pin is serviced. A request captured at one clock edge is serviced at the next edge.
- R6: When a pin is serviced its request bit is cleared. If its mask bit is 0 at that edge, `disp_valid` goes high for exactly one cycle with `disp_pin` equal to the pin number. If the mask bit is 1, there is no strobe.
- R7: A serviced level-type pin gets its in-service bit set. It stays non-pending, even with its input held high, until an end-of-interrupt releases it.
- R8: On `eoi_valid`, `eoi_vec` is compared with each pin's vector (pin i uses `pin_vec[i*VW +: VW]`). The lowest matching pin is chosen. If that pin is in service, its in-service bit is cleared. If nothing matches, or the chosen pin is not in service, nothing changes.
- R9: `irq_pending` is high exactly when at least one pin is pending.
- R10: Within one cycle, input sampling is applied after the service clear, so a level pin held high keeps its request bit. An end-of-interrupt and a service in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Global controller enable |
| pin_lvl | input | NPINS | Interrupt pin inputs |
| pin_mask | input | NPINS | Per-pin mask from the table (1 = masked) |
| pin_trig | input | NPINS | Per-pin trigger type (1 = level, 0 = edge) |
| pin_vec | input | NPINS*VW | Per-pin vector, pin i at bits i*VW +: VW |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | VW | Vector carried by the end-of-interrupt |
| disp_valid | output | 1 | One-cycle dispatch strobe |
| disp_pin | output | $clog2(NPINS) | Number of the dispatched pin |
| irq_pending | output | 1 | Some pin is pending |

## Verification
Two things can land on the same clock edge: servicing one pin and retiring another pin through an end-of-interrupt. The bench sets this up in a fixed order. First a level pin is put into service with its input held high. Then an edge pin is raised, and the end-of-interrupt for the level pin is timed so that it reaches the block on the edge where the edge pin is serviced. The scoreboard expects the edge pin to be dispatched first and the released level pin on the very next cycle. If either update is lost, the order of dispatches comes out different or one dispatch is missing.

// File: rtl/irq_service_sched.sv
module irq_service_sched #(
  parameter int NPINS = 16,
  parameter int VW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [NPINS-1:0]         pin_lvl,
  input  logic [NPINS-1:0]         pin_mask,
  input  logic [NPINS-1:0]         pin_trig,
  input  logic [NPINS*VW-1:0]      pin_vec,
  input  logic                     eoi_valid,
  input  logic [VW-1:0]            eoi_vec,
  output logic                     disp_valid,
  output logic [$clog2(NPINS)-1:0] disp_pin,
  output logic                     irq_pending
);
  localparam int PW = $clog2(NPINS);

  logic [NPINS-1:0] irr, isr, irr_n, isr_n, pend;
  logic [PW-1:0]    sel, eoi_idx;
  logic             eoi_hit;

  assign pend        = irr & ~isr;
  assign irq_pending = |pend;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NPINS; i++)
      if (pend[i]) sel = PW'(i);
  end

  always_comb begin
    eoi_hit = 1'b0;
    eoi_idx = '0;
    for (int i = NPINS-1; i >= 0; i--)
      if (pin_vec[i*VW +: VW] == eoi_vec) begin
        eoi_hit = 1'b1;
        eoi_idx = PW'(i);
      end
  end

  always_comb begin
    irr_n = irr;
    if (irq_pending) irr_n[sel] = 1'b0;
    for (int i = 0; i < NPINS; i++)
      if (i != 0 && en && !pin_mask[i]) begin
        if (pin_trig[i])     irr_n[i] = pin_lvl[i];
        else if (pin_lvl[i]) irr_n[i] = 1'b1;
      end
  end

  always_comb begin
    isr_n = isr;
    if (eoi_valid && eoi_hit) isr_n[eoi_idx] = 1'b0;
    if (irq_pending && pin_trig[sel]) isr_n[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr        <= '0;
      isr        <= '0;
      disp_valid <= 1'b0;
      disp_pin   <= '0;
    end else begin
      irr        <= irr_n;
      isr        <= isr_n;
      disp_valid <= irq_pending && !pin_mask[sel];
      disp_pin   <= sel;
    end
  end
endmodule

module irq_service_sched_chk #(
  parameter int NPINS = 16,
  parameter int PW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_valid,
  input logic [PW-1:0]    disp_pin,
  input logic             irq_pending,
  input logic [NPINS-1:0] irr,
  input logic [NPINS-1:0] isr
);
  // R2
  pin0_req_chk: assert property (@(posedge clk) disable iff (!rst_n) !irr[0]);
  // R7
  pin0_svc_chk: assert property (@(posedge clk) disable iff (!rst_n) !isr[0]);
  // R5
  disp_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pending |=> !disp_valid);
  // R6
  disp_not_in_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (((NPINS'($past(isr)) >> disp_pin) & NPINS'(1)) == '0));
  // R7
  one_svc_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr & ~$past(isr)) <= 1);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!disp_valid && isr == '0 && irr == '0));
endmodule

bind irq_service_sched irq_service_sched_chk #(.NPINS(NPINS), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_pin(disp_pin),
  .irq_pending(irq_pending), .irr(irr), .isr(isr)
);

// File: tb/sim_irq_service_sched.sv
module sim_irq_service_sched;
  localparam int NPINS = 16;
  localparam int VW    = 8;
  localparam int PW    = $clog2(NPINS);

  logic clk = 0, rst_n = 0, en = 1;
  logic [NPINS-1:0] pin_lvl = '0, pin_mask = '0, pin_trig = '0;
  logic [NPINS*VW-1:0] pin_vec;
  logic eoi_valid = 0;
  logic [VW-1:0] eoi_vec = '0;
  logic disp_valid, irq_pending;
  logic [PW-1:0] disp_pin;

  int total = 0, bad = 0;
  int expq[$];

  always #10 clk = ~clk;

  irq_service_sched #(.NPINS(NPINS), .VW(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .pin_lvl(pin_lvl), .pin_mask(pin_mask),
    .pin_trig(pin_trig), .pin_vec(pin_vec), .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
    .disp_valid(disp_valid), .disp_pin(disp_pin), .irq_pending(irq_pending)
  );

  task automatic expect_disp(input int p);
    expq.push_back(p);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && disp_valid) begin
      if (expq.size() == 0) chk("R6 unexpected dispatch", int'(disp_pin), -1);
      else chk("R5/R6 dispatch order", int'(disp_pin), expq.pop_front());
    end
  end

  task automatic pulse(input logic [NPINS-1:0] m);
    @(negedge clk) pin_lvl = pin_lvl | m;
    @(negedge clk) pin_lvl = pin_lvl & ~m;
  endtask

  task automatic send_eoi(input logic [VW-1:0] v);
    @(negedge clk) begin eoi_valid = 1; eoi_vec = v; end
    @(negedge clk) eoi_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NPINS; i++) pin_vec[i*VW +: VW] = VW'(8'h20 + i);
    pin_trig[9] = 1; pin_trig[8] = 1;
    idle(3);
    chk("R1 disp_valid in reset", disp_valid, 0);
    chk("R1 irq_pending in reset", irq_pending, 0);
    rst_n = 1;
    idle(1);
    chk("R1 irq_pending after reset", irq_pending, 0);

    // R4: edge pin pulsed then low still dispatched
    expect_disp(5);
    @(negedge clk) pin_lvl[5] = 1;
    @(negedge clk) begin pin_lvl[5] = 0; chk("R9 pending after capture", irq_pending, 1); end
    idle(3);
    chk("R4 edge request consumed", irq_pending, 0);

    // R5: priority among three edge pins
    expect_disp(10); expect_disp(7); expect_disp(3);
    pulse(16'h0488);
    idle(6);
    chk("R5 all drained", irq_pending, 0);

    // R2: pin 0, masked pin, disabled controller
    pulse(16'h0001); idle(3);
    chk("R2 pin0 ignored", irq_pending, 0);
    pin_mask[4] = 1; pulse(16'h0010); idle(2);
    pin_mask[4] = 0; idle(3);
    chk("R2 masked pin ignored", irq_pending, 0);
    en = 0; pulse(16'h0040); idle(2);
    en = 1; idle(3);
    chk("R2 disabled ignored", irq_pending, 0);

    // R3: level pin cleared by low input before its turn
    expect_disp(13);
    @(negedge clk) begin pin_lvl[8] = 1; pin_lvl[13] = 1; end
    @(negedge clk) begin pin_lvl[8] = 0; pin_lvl[13] = 0; end
    idle(4);
    chk("R3 level request withdrawn", irq_pending, 0);

    // R6: pin masked between capture and service
    @(negedge clk) pin_lvl[2] = 1;
    @(negedge clk) begin pin_lvl[2] = 0; pin_mask[2] = 1; end
    @(negedge clk) pin_mask[2] = 0;
    idle(3);
    chk("R6 masked service clears request", irq_pending, 0);

    // R7: level pin held high stays in service
    expect_disp(9);
    @(negedge clk) pin_lvl[9] = 1;
    idle(5);
    chk("R7 in service not pending", irq_pending, 0);

    // R8: unmatched and shadowed EOI ignored
    send_eoi(8'h99); idle(3);
    chk("R8 unmatched EOI ignored", irq_pending, 0);
    pin_vec[3*VW +: VW] = 8'h29;
    send_eoi(8'h29); idle(3);
    chk("R8 lowest match used", irq_pending, 0);
    pin_vec[3*VW +: VW] = 8'h23;

    // R8: matching EOI releases, level still high -> redispatch
    expect_disp(9);
    send_eoi(8'h29);
    idle(4);
    chk("R8 re-entered service", irq_pending, 0);

    // R10: service of pin 15 and EOI of pin 9 on the same edge
    expect_disp(15); expect_disp(9);
    @(negedge clk) pin_lvl[15] = 1;
    @(negedge clk) begin pin_lvl[15] = 0; eoi_valid = 1; eoi_vec = 8'h29; end
    @(negedge clk) eoi_valid = 0;
    idle(4);
    chk("R10 both updates applied", irq_pending, 0);

    // R3: lowering the level pin then retiring leaves nothing pending
    @(negedge clk) pin_lvl[9] = 0;
    send_eoi(8'h29); idle(3);
    chk("R3 level low no request", irq_pending, 0);

    chk("R5 scoreboard empty", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule